// File: doc/BRIEF.md
# Video Memory Access Port

This block is a host-facing register window in front of a byte-organised video memory. A host bus carries a 16-bit write address, a write byte and a write strobe. A separate read address returns a byte combinationally. The window holds 64 byte registers starting at 0x2100. Two of these registers form a 16-bit word address. Two are data-write ports that each deposit one byte into video memory. Two are read-back registers that show the last byte sent through each data port. Every other register in the window is plain storage.

The word address is cut to 15 bits and doubled to give a byte address. A byte written to the low data port lands at the odd byte, byte address + 1. A byte written to the high data port lands at the even byte. The host may send the two halves in either order, and each commits on its own strobe. The word address never advances by itself.

The video memory is 2**VMEM_AW bytes. With VMEM_AW = 16 it is the full 64 KiB. Byte-address bits above VMEM_AW are dropped. A registered debug read port lets a test environment inspect the memory contents.

Top module: `vmem_access_port`

## Requirements
- R1: While rst_ni is low, and right after it rises, every window register reads 0x00.
- R2: A write to any window offset other than the two read-back offsets stores the byte, and a later read of that address returns it. This includes 0x2115 and the data ports 0x2118 and 0x2119.
- R3: Writes to 0x2139 and 0x213A are ignored, and the value held there is unchanged.
- R4: The byte address is ({reg 0x2117, reg 0x2116} & 0x7FFF) * 2, so bit 15 of the word address has no effect. Memory is indexed by the low VMEM_AW bits of the byte address.
- R5: A write to 0x2118 stores the byte at byte address + 1. A write to 0x2119 stores it at byte address. The two may come in either order.
- R6: A write to 0x2118 also places the byte in 0x2139, and a write to 0x2119 also places it in 0x213A, in the same clock edge.
- R7: Data-port writes leave the word address unchanged, and the value in 0x2115 has no effect on where the bytes go.
- R8: Writes outside 0x2100..0x213F change nothing, and reads outside that range return 0x00.
- R9: dbg_data_o returns the memory byte at dbg_addr_i one clock after it is sampled. If that byte is written in the same edge, the previous contents are returned.
- R10: Reset does not clear the video memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset for the window registers |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 16 | Write address |
| wr_data_i | input | 8 | Write byte |
| rd_addr_i | input | 16 | Register read address |
| rd_data_o | output | 8 | Register read byte, combinational |
| dbg_addr_i | input | VMEM_AW | Debug byte index into video memory |
| dbg_data_o | output | 8 | Debug read byte, one cycle latency |

## Verification
The cycle that matters is one where a data-port write and a debug read of the very byte being written fall on the same edge. The bench provokes this by pointing dbg_addr_i at the target byte during the strobe cycle. It expects the old contents one cycle later, and the new byte only on the following read. The reference model takes its expected debug byte before it applies the write of that edge, so an ordering fault on either side shows up as a mismatch.

// File: rtl/vmap_pkg.sv
package vmap_pkg;
  localparam logic [15:0] WIN_BASE = 16'h2100;
  // offsets from WIN_BASE
  localparam int OFF_WADDR_LO = 'h16;
  localparam int OFF_WADDR_HI = 'h17;
  localparam int OFF_DATA_LO  = 'h18;
  localparam int OFF_DATA_HI  = 'h19;
  localparam int OFF_RB_LO    = 'h39;
  localparam int OFF_RB_HI    = 'h3A;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_PLAIN,
    ACC_DATA_LO,
    ACC_DATA_HI,
    ACC_RB
  } acc_kind_e;
endpackage

// File: rtl/vmap_decode.sv
module vmap_decode
  import vmap_pkg::*;
#(
  parameter int REG_AW = 6
) (
  input  logic [15:0]       addr_i,
  output logic              hit_o,
  output logic [REG_AW-1:0] off_o,
  output acc_kind_e         kind_o
);
  localparam logic [15-REG_AW:0] BASE_HI = WIN_BASE[15:REG_AW];

  assign hit_o = (addr_i[15:REG_AW] == BASE_HI);
  assign off_o = addr_i[REG_AW-1:0];

  always_comb begin
    if (!hit_o) begin
      kind_o = ACC_NONE;
    end else begin
      case (off_o)
        REG_AW'(OFF_DATA_LO): kind_o = ACC_DATA_LO;
        REG_AW'(OFF_DATA_HI): kind_o = ACC_DATA_HI;
        REG_AW'(OFF_RB_LO),
        REG_AW'(OFF_RB_HI):   kind_o = ACC_RB;
        default:              kind_o = ACC_PLAIN;
      endcase
    end
  end
endmodule

// File: rtl/vmap_regfile.sv
module vmap_regfile
  import vmap_pkg::*;
#(
  parameter int REG_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_off_i,
  input  acc_kind_e         wr_kind_i,
  input  logic [7:0]        wr_data_i,
  input  logic              rd_hit_i,
  input  logic [REG_AW-1:0] rd_off_i,
  output logic [7:0]        rd_data_o,
  output logic [14:0]       word_addr_o
);
  localparam int NREG = 1 << REG_AW;
  localparam logic [REG_AW-1:0] RB_LO = REG_AW'(OFF_RB_LO);
  localparam logic [REG_AW-1:0] RB_HI = REG_AW'(OFF_RB_HI);
  localparam logic [REG_AW-1:0] WA_LO = REG_AW'(OFF_WADDR_LO);
  localparam logic [REG_AW-1:0] WA_HI = REG_AW'(OFF_WADDR_HI);

  logic [7:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en_i) begin
      if (wr_kind_i != ACC_RB) regs_q[wr_off_i] <= wr_data_i;
      if (wr_kind_i == ACC_DATA_LO) regs_q[RB_LO] <= wr_data_i;
      if (wr_kind_i == ACC_DATA_HI) regs_q[RB_HI] <= wr_data_i;
    end
  end

  assign rd_data_o   = rd_hit_i ? regs_q[rd_off_i] : 8'h00;
  // bit 15 of the word address is dropped here
  assign word_addr_o = {regs_q[WA_HI][6:0], regs_q[WA_LO]};

  a_r3_rb_lo_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_kind_i == ACC_RB && wr_off_i == RB_LO) |=> $stable(regs_q[RB_LO]));
  a_r3_rb_hi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_kind_i == ACC_RB && wr_off_i == RB_HI) |=> $stable(regs_q[RB_HI]));
  a_r6_mirror_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_kind_i == ACC_DATA_LO) |=> regs_q[RB_LO] == $past(wr_data_i));
  a_r6_mirror_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_kind_i == ACC_DATA_HI) |=> regs_q[RB_HI] == $past(wr_data_i));
  a_r7_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_kind_i == ACC_DATA_LO || wr_kind_i == ACC_DATA_HI))
    |=> $stable(word_addr_o));
endmodule

// File: rtl/vmap_addr_gen.sv
module vmap_addr_gen #(
  parameter int VMEM_AW = 11
) (
  input  logic [14:0]        word_addr_i,
  input  logic               lo_sel_i,
  output logic [VMEM_AW-1:0] mem_idx_o
);
  // doubled word address; the low data port selects the odd byte
  assign mem_idx_o = VMEM_AW'({word_addr_i, lo_sel_i});
endmodule

// File: rtl/vmap_vram.sv
module vmap_vram #(
  parameter int VMEM_AW = 11
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [VMEM_AW-1:0] waddr_i,
  input  logic [7:0]         wdata_i,
  input  logic [VMEM_AW-1:0] raddr_i,
  output logic [7:0]         rdata_o
);
  localparam int DEPTH = 1 << VMEM_AW;

  logic [7:0] mem_q [DEPTH];

  // no reset: contents survive rst_ni; read returns pre-write data
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/vmem_access_port.sv
module vmem_access_port
  import vmap_pkg::*;
#(
  parameter int VMEM_AW = 11,
  parameter int REG_AW  = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [15:0]        wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic [15:0]        rd_addr_i,
  output logic [7:0]         rd_data_o,
  input  logic [VMEM_AW-1:0] dbg_addr_i,
  output logic [7:0]         dbg_data_o
);
  localparam logic [15-REG_AW:0] BASE_HI = WIN_BASE[15:REG_AW];

  logic              w_hit;
  logic [REG_AW-1:0] w_off;
  acc_kind_e         w_kind;
  logic              rd_hit;
  logic [14:0]       word_addr;
  logic [VMEM_AW-1:0] vram_idx;
  logic              vram_we;

  vmap_decode #(.REG_AW(REG_AW)) u_wdec (
    .addr_i (wr_addr_i),
    .hit_o  (w_hit),
    .off_o  (w_off),
    .kind_o (w_kind)
  );

  assign rd_hit = (rd_addr_i[15:REG_AW] == BASE_HI);

  vmap_regfile #(.REG_AW(REG_AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i & w_hit),
    .wr_off_i    (w_off),
    .wr_kind_i   (w_kind),
    .wr_data_i   (wr_data_i),
    .rd_hit_i    (rd_hit),
    .rd_off_i    (rd_addr_i[REG_AW-1:0]),
    .rd_data_o   (rd_data_o),
    .word_addr_o (word_addr)
  );

  vmap_addr_gen #(.VMEM_AW(VMEM_AW)) u_agen (
    .word_addr_i (word_addr),
    .lo_sel_i    (w_kind == ACC_DATA_LO),
    .mem_idx_o   (vram_idx)
  );

  assign vram_we = rst_ni & wr_en_i & ((w_kind == ACC_DATA_LO) | (w_kind == ACC_DATA_HI));

  vmap_vram #(.VMEM_AW(VMEM_AW)) u_vram (
    .clk_i   (clk_i),
    .we_i    (vram_we),
    .waddr_i (vram_idx),
    .wdata_i (wr_data_i),
    .raddr_i (dbg_addr_i),
    .rdata_o (dbg_data_o)
  );

  a_r5_lo_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vram_we && w_kind == ACC_DATA_LO) |-> vram_idx[0]);
  a_r5_hi_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vram_we && w_kind == ACC_DATA_HI) |-> !vram_idx[0]);
  a_r8_outside_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !w_hit) |-> !vram_we);
endmodule

// File: tb/vmem_access_port_test.sv
`timescale 1ns/1ps
module vmem_access_port_test;
  localparam int VAW  = 11;
  localparam int MASK = (1 << VAW) - 1;
  localparam int BASE = 'h2100;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           wr_en_i = 1'b0;
  logic [15:0]    wr_addr_i = '0;
  logic [7:0]     wr_data_i = '0;
  logic [15:0]    rd_addr_i = '0;
  logic [7:0]     rd_data_o;
  logic [VAW-1:0] dbg_addr_i = '0;
  logic [7:0]     dbg_data_o;

  int n_chk = 0;
  int n_fail = 0;
  int mreg [64];
  int mmem [int];
  bit have_exp = 0;
  int exp_dbg = 0;

  always #2 clk_i = ~clk_i;

  vmem_access_port #(.VMEM_AW(VAW)) uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .dbg_addr_i (dbg_addr_i),
    .dbg_data_o (dbg_data_o)
  );

  function automatic int model_read(int a);
    if (a >= BASE && a < BASE + 64) return mreg[a - BASE];
    return 0;
  endfunction

  function automatic void model_write(int a, int d);
    int off;
    int w;
    if (a < BASE || a >= BASE + 64) return;
    off = a - BASE;
    if (off == 'h39 || off == 'h3A) return;
    mreg[off] = d;
    w = ((mreg['h17] << 8) | mreg['h16]) & 'h7FFF;
    if (off == 'h18) begin
      mmem[(w * 2 + 1) & MASK] = d;
      mreg['h39] = d;
    end else if (off == 'h19) begin
      mmem[(w * 2) & MASK] = d;
      mreg['h3A] = d;
    end
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input int expv);
    n_chk++;
    if (act !== 8'(expv)) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, 8'(expv));
    end
  endtask

  task automatic cyc(input string tag, input bit we, input int a, input int d,
                     input int ra, input int da);
    @(negedge clk_i);
    wr_en_i = we; wr_addr_i = a[15:0]; wr_data_i = d[7:0];
    rd_addr_i = ra[15:0]; dbg_addr_i = da[VAW-1:0];
    #1;
    if (!rst_ni) for (int i = 0; i < 64; i++) mreg[i] = 0;
    chk(tag, "rd_data_o", rd_data_o, model_read(ra));
    if (have_exp) chk(tag, "dbg_data_o", dbg_data_o, exp_dbg);
    @(posedge clk_i);
    have_exp = mmem.exists(da & MASK);
    if (have_exp) exp_dbg = mmem[da & MASK];
    if (rst_ni && we) model_write(a, d);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mreg[i] = 0;
    // R1: reset state
    cyc("R1", 0, 0, 0, 'h2116, 0);
    cyc("R1", 1, 'h2100, 'h33, 'h2139, 0);
    cyc("R1", 0, 0, 0, 'h2115, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    cyc("R1", 0, 0, 0, 'h2117, 0);
    cyc("R1", 0, 0, 0, 'h213A, 0);
    cyc("R1", 0, 0, 0, 'h2100, 0);
    // R2: plain storage
    cyc("R2", 1, 'h2115, 'h80, 'h2115, 0);
    cyc("R2", 1, 'h2100, 'h5A, 'h2115, 0);
    cyc("R2", 1, 'h213F, 'hC3, 'h2100, 0);
    cyc("R2", 0, 0, 0, 'h213F, 0);
    // R5: word address 0, high then low
    cyc("R5", 1, 'h2116, 'h00, 'h2116, 0);
    cyc("R5", 1, 'h2117, 'h00, 'h2117, 0);
    cyc("R5", 1, 'h2119, 'hAB, 'h2116, 0);
    cyc("R5", 1, 'h2118, 'hCD, 'h213A, 0);
    cyc("R6", 0, 0, 0, 'h2139, 0);
    cyc("R5", 0, 0, 0, 'h2119, 1);
    cyc("R5", 0, 0, 0, 'h2118, 1);
    // R5/R4: word 0x1234, low then high
    cyc("R4", 1, 'h2117, 'h12, 'h2117, 0);
    cyc("R4", 1, 'h2116, 'h34, 'h2116, 0);
    cyc("R5", 1, 'h2118, 'h77, 'h2116, 'h2469);
    cyc("R6", 1, 'h2119, 'h66, 'h2139, 'h2468);
    cyc("R6", 0, 0, 0, 'h213A, 'h2469);
    cyc("R2", 0, 0, 0, 'h2118, 'h2468);
    cyc("R7", 0, 0, 0, 'h2116, 0);
    cyc("R7", 0, 0, 0, 'h2117, 0);
    // R4: word 0xFFFF and bit 15 ignored
    cyc("R4", 1, 'h2117, 'hFF, 0, 0);
    cyc("R4", 1, 'h2116, 'hFF, 0, 0);
    cyc("R4", 1, 'h2119, 'hAB, 0, 'hFFFE);
    cyc("R4", 1, 'h2118, 'hCD, 0, 'hFFFF);
    cyc("R4", 0, 0, 0, 'h213A, 'hFFFE);
    cyc("R4", 1, 'h2117, 'h7F, 'h2139, 'hFFFF);
    cyc("R4", 1, 'h2118, 'h11, 'h2117, 'hFFFF);
    cyc("R4", 0, 0, 0, 'h2139, 'hFFFF);
    cyc("R4", 0, 0, 0, 'h2118, 'h7FFE);
    // R3: read-back writes ignored
    cyc("R3", 1, 'h2139, 'h00, 'h2139, 0);
    cyc("R3", 1, 'h213A, 'h55, 'h2139, 0);
    cyc("R3", 0, 0, 0, 'h213A, 0);
    // R7: no auto-advance, 0x2115 inert
    cyc("R7", 1, 'h2115, 'h8F, 'h2115, 0);
    cyc("R7", 1, 'h2118, 'h21, 'h2116, 'hFFFF);
    cyc("R7", 1, 'h2118, 'h22, 'h2117, 'hFFFF);
    cyc("R7", 0, 0, 0, 'h2116, 'hFFFF);
    cyc("R7", 0, 0, 0, 'h2117, 'hFFFE);
    cyc("R7", 0, 0, 0, 'h2115, 0);
    // R8: outside the window
    cyc("R8", 1, 'h2216, 'h00, 'h2216, 0);
    cyc("R8", 1, 'h2018, 'h44, 'h2116, 'hFFFF);
    cyc("R8", 1, 'h20FF, 'h99, 'h20FF, 'hFFFF);
    cyc("R8", 0, 0, 0, 'h2140, 0);
    cyc("R8", 0, 0, 0, 'h0000, 0);
    // R9: write and debug read of the same byte in one edge
    cyc("R9", 1, 'h2118, 'h99, 'h2139, 'hFFFF);
    cyc("R9", 0, 0, 0, 'h2139, 'hFFFF);
    cyc("R9", 1, 'h2119, 'h5C, 'h213A, 'hFFFE);
    cyc("R9", 0, 0, 0, 'h213A, 'hFFFE);
    cyc("R9", 0, 0, 0, 0, 0);
    // R10: memory survives reset
    @(negedge clk_i); rst_ni = 1'b0;
    cyc("R10", 0, 0, 0, 'h2139, 'h2468);
    cyc("R10", 0, 0, 0, 'h2116, 'h2469);
    cyc("R10", 0, 0, 0, 'h2117, 'hFFFF);
    @(negedge clk_i); rst_ni = 1'b1;
    cyc("R10", 0, 0, 0, 'h213A, 'hFFFE);
    cyc("R10", 0, 0, 0, 'h2115, 1);
    cyc("R10", 0, 0, 0, 'h2118, 0);
    cyc("R10", 0, 0, 0, 0, 0);
    summary();
    $finish;
  end
endmodule